// File: doc/BRIEF.md
# SSI Absolute Position Transmitter

This block is the encoder side of a Synchronous Serial Interface link. A controller idles its clock line high and, when it wants a reading, sends a burst of clock pulses. The first falling clock edge freezes the current position word together with one special (status) bit. The frame is then shifted out MSB first, one bit per rising clock edge, with the special bit last. The data line idles high. After a frame it is pulled low and kept low by a retriggerable monoflop timer. The line returns high only once clocking has stopped for the full monoflop time.

If the controller keeps clocking before the monoflop expires, the block repeats the word it already froze instead of fetching a new one. This ring-slide repetition lets the controller compare two copies and detect line errors. Each copy is followed by one low separator bit. The incoming SSI clock is asynchronous to the block. It passes through a two-flop synchroniser and is edge-detected in the system clock domain. The monoflop length is a parameter in system clock cycles: 10 to 30 us at the system clock rate, for SSI clock rates up to 1 MHz.

Top module: `ssi_position_tx`

## Requirements
- R1: Out of reset, and whenever no transfer is in progress, `data_out` is high.
- R2: The first falling edge of `ssi_clk_in` while idle captures the frame {`pos_in`, `spec_in`}. Changes on `pos_in` or `spec_in` after that edge do not alter any bit sent until the transfer ends.
- R3: Rising edge k of a transfer (k = 1..POS_W+1) drives frame bit POS_W+1-k onto `data_out`, within 3 system clock cycles. The frame's MSB is `pos_in[POS_W-1]` and its LSB is the special bit.
- R4: Between the capturing falling edge and the first rising edge, `data_out` stays high.
- R5: Rising edge POS_W+2 drives `data_out` low. The last presented level is held until the next rising edge or until the monoflop expires.
- R6: Every falling edge during a transfer restarts the monoflop. MONO_CYC system cycles after the last falling edge is seen with no further edge, the transfer ends and `data_out` returns high.
- R7: If clocking continues before the monoflop expires, rising edges POS_W+3 onward repeat the same captured frame from its MSB. Each repeat is followed by one low separator bit (ring slide).
- R8: After the monoflop has expired, the next falling edge captures a fresh frame. This also holds when clocking stopped in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ssi_clk_in | input | 1 | SSI clock from the controller, asynchronous, idles high |
| pos_in | input | POS_W | Current absolute position |
| spec_in | input | 1 | Special bit appended after the position LSB |
| data_out | output | 1 | Serial data line to the controller, idles high |

## Verification
The hardest state to reach is a transfer that ends partway through a word or after an arbitrary number of ring-slide repeats. At that point the bit counter sits at some value other than zero. A following burst must still start cleanly from a newly captured MSB. The stimulus uses bursts of random length, random half-periods and random words. It changes `pos_in` right after every capturing edge, and it inserts pauses both shorter and longer than the monoflop. This exercises mid-word aborts, continued repetition and fresh captures, and catches any stale word or counter value.

// File: rtl/ssi_position_tx.sv
module ssi_position_tx #(
  parameter int POS_W    = 24,
  parameter int MONO_CYC = 1000,
  localparam int FW = POS_W + 1,
  localparam int IW = $clog2(FW + 1),
  localparam int MW = $clog2(MONO_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ssi_clk_in,
  input  logic [POS_W-1:0] pos_in,
  input  logic             spec_in,
  output logic             data_out
);

  logic [2:0]    sync_q;
  logic          rise_ev, fall_ev;
  logic          busy_q;
  logic [FW-1:0] frame_q;
  logic [IW-1:0] idx_q;
  logic [MW-1:0] mono_q;
  logic          expire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], ssi_clk_in};

  assign rise_ev = sync_q[1] & ~sync_q[2];
  assign fall_ev = ~sync_q[1] & sync_q[2];
  assign expire  = busy_q && !fall_ev && mono_q == MW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      data_out <= 1'b1;
      frame_q  <= '0;
      idx_q    <= '0;
      mono_q   <= '0;
    end else if (!busy_q) begin
      data_out <= 1'b1;
      if (fall_ev) begin
        frame_q <= {pos_in, spec_in};
        busy_q  <= 1'b1;
        idx_q   <= '0;
        mono_q  <= MW'(MONO_CYC);
      end
    end else if (expire) begin
      busy_q   <= 1'b0;
      data_out <= 1'b1;
      idx_q    <= '0;
      mono_q   <= '0;
    end else begin
      if (fall_ev) mono_q <= MW'(MONO_CYC);
      else         mono_q <= mono_q - MW'(1);
      if (rise_ev) begin
        if (idx_q == IW'(FW)) begin
          data_out <= 1'b0;
          idx_q    <= '0;
        end else begin
          data_out <= frame_q[FW-1];
          frame_q  <= {frame_q[FW-2:0], frame_q[FW-1]};
          idx_q    <= idx_q + IW'(1);
        end
      end
    end
  end

endmodule

module ssi_position_tx_chk #(
  parameter int FW = 25,
  parameter int MONO_CYC = 1000,
  parameter int IW = 5,
  parameter int MW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_out,
  input logic          busy,
  input logic          rise_ev,
  input logic          fall_ev,
  input logic [FW-1:0] frame_q,
  input logic [IW-1:0] idx_q,
  input logic [MW-1:0] mono_q
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> data_out);

  assert_frame_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(rise_ev) |-> $stable(frame_q));

  assert_data_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> $past(rise_ev) || $fell(busy));

  assert_first_fall_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && fall_ev |=> data_out && idx_q == '0);

  assert_mono_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> mono_q == MW'(MONO_CYC));

  assert_mono_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mono_q != '0 && mono_q <= MW'(MONO_CYC));

  assert_index_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(FW));

  assert_expiry_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> data_out);

endmodule

bind ssi_position_tx ssi_position_tx_chk #(.FW(FW), .MONO_CYC(MONO_CYC), .IW(IW), .MW(MW)) chk_i (
  .clk(clk), .rst_n(rst_n), .data_out(data_out), .busy(busy_q),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .frame_q(frame_q),
  .idx_q(idx_q), .mono_q(mono_q)
);

// File: tb/ssi_position_tx_test.sv
module ssi_position_tx_test;
  localparam int POS_W = 24;
  localparam int FW    = POS_W + 1;
  localparam int MONO  = 60;

  logic clk = 0, rst_n = 0, ssi = 1, spec = 0;
  logic [POS_W-1:0] pos = '0;
  logic data;
  int checks = 0, fails = 0;

  ssi_position_tx #(.POS_W(POS_W), .MONO_CYC(MONO)) uut (
    .clk(clk), .rst_n(rst_n), .ssi_clk_in(ssi), .pos_in(pos),
    .spec_in(spec), .data_out(data));

  always #10 clk = ~clk;

  function automatic logic exp_bit(logic [FW-1:0] fr, int p);
    int k = (p - 1) % (FW + 1);
    return (k == FW) ? 1'b0 : fr[FW-1-k];
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: data_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(int n, int hp, output logic last);
    logic [FW-1:0] fr;
    fr = {pos, spec};
    for (int p = 1; p <= n; p++) begin
      ssi = 0; waitn(hp);
      if (p == 1) begin
        check("R4", data, 1'b1);
        pos = POS_W'($urandom); spec = 1'($urandom);
      end
      ssi = 1; waitn(hp);
      last = exp_bit(fr, p);
      check((p <= FW) ? "R3" : (p == FW + 1) ? "R5" : "R7 R2", data, last);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic last;
    void'($urandom(32'd1234));
    waitn(3);
    check("R1", data, 1'b1);
    rst_n = 1;
    waitn(5);
    check("R1", data, 1'b1);

    pos = 24'hA5C3F0; spec = 1;
    burst(FW + 1, 6, last);
    waitn(20); check("R5", data, 1'b0);
    waitn(50); check("R6", data, 1'b1);

    pos = 24'h000001; spec = 0;
    burst(2 * (FW + 1) + 3, 4, last);
    waitn(20); check("R5 R7", data, last);
    waitn(50); check("R6", data, 1'b1);

    pos = 24'hFFFFFF; spec = 1;
    burst(10, 5, last);
    waitn(100); check("R8", data, 1'b1);
    pos = 24'h123456; spec = 0;
    burst(FW + 1, 5, last);
    waitn(80); check("R6 R8", data, 1'b1);

    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom_range(0, 3 * FW));
      int hp = 4 + int'($urandom_range(0, 6));
      pos = POS_W'($urandom); spec = 1'($urandom);
      burst(n, hp, last);
      waitn(20); check("R5", data, last);
      waitn(50); check("R6 R8", data, 1'b1);
    end
    finish_up();
  end
endmodule